// File: doc/BRIEF.md
# Word-Aligned DMA Command Queue Engine

This block is a register-programmed DMA engine. Software sets a source address, a destination address and two lengths counted in 32-bit words. Writing the destination length captures all four values as one command and pushes it into a small in-order queue. The engine takes the command at the head of the queue and works through it in chunks of at most 1024 bytes. It reads source words through a memory port that moves one word per valid/ready beat.

When the loopback control bit is set, each word read is written to the destination straight away, and both the destination address and the destination count advance. When loopback is clear, the source data goes to a downstream consumer that sits outside this block, and the destination count stays where it was. A command retires only when both its remaining counts reach zero. On retirement the engine raises done flags in an interrupt status register, and software clears those flags by writing ones. A level interrupt output is high while any flag is set whose mask bit is clear.

Top module: `wdma_cmd_engine`

## Requirements
- R1: A write to the destination length register (byte offset 0x24) captures one command from the source address (0x18), destination address (0x1C), source length (0x20) and the written destination length. Both captured addresses have bits 1:0 forced to zero, so every memory access is word aligned.
- R2: Lengths count 32-bit words and become byte counts equal to four times the word count. Only bits 26:0 of each length register are writable, and bits 31:27 read as zero.
- R3: Each chunk is the smaller of 1024 bytes and the remaining source bytes, and in loopback mode also the remaining destination bytes. No chunk issues more than 256 read beats. A command of any length reads every source word exactly once.
- R4: In loopback mode (bit 4 of the control register at 0x80) each word read is written next to the destination, in order, with the destination address rising by 4 per word. A request holds its address and direction until it is accepted.
- R5: With loopback clear the engine issues no writes and never decrements the destination count. A command retires only if its destination length was zero; otherwise it stays at the head and the queue does not drain.
- R6: When a command retires, status bits 13 (done) and 12 (part done) at 0x0C are set. Writing a 1 to a bit clears it, and a hardware set wins over a clear in the same cycle. The register resets to zero.
- R7: The mask register (0x10) resets to all ones. The irq output is high exactly when some status bit is set and its mask bit is 0.
- R8: Register 0x14 reports queue full in bit 31 and queue empty in bit 30. After reset it reads 0x40000000.
- R9: The queue holds 4 commands and serves them in push order. A push while the queue is full is discarded and sets status bit 14 (overflow).
- R10: A command with both lengths zero retires with no memory access. In loopback mode, a command whose destination count runs out before its source count stalls at the head with no further beats and no done flag.
- R11: The address, length, mask and loopback control fields read back what was last written. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid in the accepting cycle of a read |
| irq | output | 1 | Masked level interrupt |

## Verification
The bench runs transfers longer than 256 words while mem_ready stalls at random. An engine with a wrong chunk boundary would skip or repeat source words, and the bench would see it in the read-address log or in the destination contents. Commands are programmed with unaligned addresses, a zero-length command, and a non-loopback command that has a nonzero destination length. A design that kept the low address bits, touched memory for an empty command, or retired the non-loopback command would show a wrong address, stray beats or a done flag. A loopback command whose destination runs out early must stall, and a design that kept reading would be caught. A fifth push into a full queue must be dropped and flagged, so a design that overwrote a queued command would show too many reads or reads out of order.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
    localparam int LEN_W  = 27;
    localparam int BYTE_W = LEN_W + 2;

    localparam logic [7:0] OFF_STS  = 8'h0C;
    localparam logic [7:0] OFF_MASK = 8'h10;
    localparam logic [7:0] OFF_STAT = 8'h14;
    localparam logic [7:0] OFF_SRC  = 8'h18;
    localparam logic [7:0] OFF_DST  = 8'h1C;
    localparam logic [7:0] OFF_SLEN = 8'h20;
    localparam logic [7:0] OFF_DLEN = 8'h24;
    localparam logic [7:0] OFF_MISC = 8'h80;

    typedef struct packed {
        logic [31:0]       src;
        logic [31:0]       dst;
        logic [BYTE_W-1:0] src_bytes;
        logic [BYTE_W-1:0] dst_bytes;
    } cmd_t;

    typedef enum logic [2:0] {
        MV_IDLE,
        MV_EVAL,
        MV_READ,
        MV_WRITE,
        MV_ADV
    } mv_state_e;
endpackage

// File: rtl/wdma_cmd_queue.sv
module wdma_cmd_queue
    import wdma_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  cmd_t push_cmd,
    input  logic pop,
    output cmd_t head,
    output logic full,
    output logic empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } qptr_t;

    qptr_t ptr_d, ptr_q;
    cmd_t  slot_q [DEPTH];
    logic  push_ok, pop_ok;

    assign full    = (ptr_q.cnt == CW'(DEPTH));
    assign empty   = (ptr_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = slot_q[ptr_q.rd];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        if (push_ok) ptr_d.wr = bump(ptr_q.wr);
        if (pop_ok)  ptr_d.rd = bump(ptr_q.rd);
        case ({push_ok, pop_ok})
            2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
            2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                slot_q[i] <= '0;
            else if (push_ok && ptr_q.wr == PW'(i))    slot_q[i] <= push_cmd;
        end
    end
endmodule

// File: rtl/wdma_chunk_calc.sv
module wdma_chunk_calc
    import wdma_pkg::*;
#(
    parameter int CHUNK_BYTES = 1024
) (
    input  logic [BYTE_W-1:0] src_rem,
    input  logic [BYTE_W-1:0] dst_rem,
    input  logic              loopback,
    output logic [BYTE_W-1:0] chunk
);
    localparam logic [BYTE_W-1:0] CAP = BYTE_W'(CHUNK_BYTES);
    logic [BYTE_W-1:0] src_lim;

    always_comb begin
        src_lim = (src_rem < CAP) ? src_rem : CAP;
        chunk   = (loopback && dst_rem < src_lim) ? dst_rem : src_lim;
    end
endmodule

// File: rtl/wdma_mover.sv
module wdma_mover
    import wdma_pkg::*;
#(
    parameter int CHUNK_BYTES = 1024,
    parameter int BEAT_W      = $clog2(CHUNK_BYTES / 4) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_empty,
    input  cmd_t              head,
    input  logic              loopback,
    output logic              pop,
    output logic              done,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic [BEAT_W-1:0] beats_left,
    output logic              lb_active
);
    typedef struct packed {
        mv_state_e         st;
        logic [31:0]       src;
        logic [31:0]       dst;
        logic [BYTE_W-1:0] src_rem;
        logic [BYTE_W-1:0] dst_rem;
        logic [BYTE_W-1:0] chunk;
        logic [BEAT_W-1:0] beats;
        logic              lb;
        logic [31:0]       data;
    } mv_t;

    mv_t mv_d, mv_q;
    logic [BYTE_W-1:0] next_chunk;

    wdma_chunk_calc #(.CHUNK_BYTES(CHUNK_BYTES)) u_chunk (
        .src_rem (mv_q.src_rem),
        .dst_rem (mv_q.dst_rem),
        .loopback(loopback),
        .chunk   (next_chunk)
    );

    assign mem_valid  = (mv_q.st == MV_READ) || (mv_q.st == MV_WRITE);
    assign mem_we     = (mv_q.st == MV_WRITE);
    assign mem_addr   = (mv_q.st == MV_WRITE) ? mv_q.dst : mv_q.src;
    assign mem_wdata  = mv_q.data;
    assign beats_left = mv_q.beats;
    assign lb_active  = mv_q.lb;

    always_comb begin
        mv_d = mv_q;
        pop  = 1'b0;
        done = 1'b0;
        case (mv_q.st)
            MV_IDLE: begin
                if (!q_empty) begin
                    mv_d.src     = head.src;
                    mv_d.dst     = head.dst;
                    mv_d.src_rem = head.src_bytes;
                    mv_d.dst_rem = head.dst_bytes;
                    mv_d.st      = MV_EVAL;
                end
            end
            MV_EVAL: begin
                if (mv_q.src_rem == '0 && mv_q.dst_rem == '0) begin
                    pop     = 1'b1;
                    done    = 1'b1;
                    mv_d.st = MV_IDLE;
                end else if (next_chunk != '0) begin
                    mv_d.chunk = next_chunk;
                    mv_d.beats = next_chunk[BEAT_W+1:2];
                    mv_d.lb    = loopback;
                    mv_d.st    = MV_READ;
                end
            end
            MV_READ: begin
                if (mem_ready) begin
                    mv_d.data = mem_rdata;
                    mv_d.src  = mv_q.src + 32'd4;
                    if (mv_q.lb) begin
                        mv_d.st = MV_WRITE;
                    end else if (mv_q.beats == BEAT_W'(1)) begin
                        mv_d.st = MV_ADV;
                    end else begin
                        mv_d.beats = mv_q.beats - 1'b1;
                    end
                end
            end
            MV_WRITE: begin
                if (mem_ready) begin
                    mv_d.dst = mv_q.dst + 32'd4;
                    if (mv_q.beats == BEAT_W'(1)) begin
                        mv_d.st = MV_ADV;
                    end else begin
                        mv_d.beats = mv_q.beats - 1'b1;
                        mv_d.st    = MV_READ;
                    end
                end
            end
            MV_ADV: begin
                mv_d.src_rem = mv_q.src_rem - mv_q.chunk;
                if (mv_q.lb) mv_d.dst_rem = mv_q.dst_rem - mv_q.chunk;
                mv_d.beats = '0;
                mv_d.st    = MV_EVAL;
            end
            default: mv_d.st = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mv_q <= '{st: MV_IDLE, default: '0};
        else        mv_q <= mv_d;
    end
endmodule

// File: rtl/wdma_cmd_engine.sv
module wdma_cmd_engine
    import wdma_pkg::*;
#(
    parameter int QDEPTH      = 4,
    parameter int CHUNK_BYTES = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_valid,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata,
    output logic        irq
);
    localparam int BEAT_W = $clog2(CHUNK_BYTES / 4) + 1;

    typedef struct packed {
        logic [31:0]      src_addr;
        logic [31:0]      dst_addr;
        logic [LEN_W-1:0] src_len;
        logic [LEN_W-1:0] dst_len;
        logic [2:0]       flags;   // {overflow, done, part done}
        logic [31:0]      mask;
        logic             lb;
    } csr_t;

    csr_t csr_d, csr_q;

    logic              push_req, q_full, q_empty, q_overflow;
    logic              mv_pop, mv_done, lb_active;
    logic [BEAT_W-1:0] beats_left;
    cmd_t              new_cmd, head_cmd;
    logic [31:0]       sts_vec, stat_vec;

    assign push_req   = reg_we && (reg_addr == OFF_DLEN);
    assign q_overflow = push_req && q_full;
    assign sts_vec    = {17'b0, csr_q.flags, 12'b0};
    assign stat_vec   = {q_full, q_empty, 30'b0};
    assign irq        = |(sts_vec & ~csr_q.mask);

    always_comb begin
        new_cmd.src       = {csr_q.src_addr[31:2], 2'b00};
        new_cmd.dst       = {csr_q.dst_addr[31:2], 2'b00};
        new_cmd.src_bytes = {csr_q.src_len, 2'b00};
        new_cmd.dst_bytes = {reg_wdata[LEN_W-1:0], 2'b00};
    end

    wdma_cmd_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push_req),
        .push_cmd(new_cmd),
        .pop     (mv_pop),
        .head    (head_cmd),
        .full    (q_full),
        .empty   (q_empty)
    );

    wdma_mover #(.CHUNK_BYTES(CHUNK_BYTES), .BEAT_W(BEAT_W)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_empty   (q_empty),
        .head      (head_cmd),
        .loopback  (csr_q.lb),
        .pop       (mv_pop),
        .done      (mv_done),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .beats_left(beats_left),
        .lb_active (lb_active)
    );

    always_comb begin
        csr_d = csr_q;
        if (reg_we) begin
            case (reg_addr)
                OFF_SRC:  csr_d.src_addr = reg_wdata;
                OFF_DST:  csr_d.dst_addr = reg_wdata;
                OFF_SLEN: csr_d.src_len  = reg_wdata[LEN_W-1:0];
                OFF_DLEN: csr_d.dst_len  = reg_wdata[LEN_W-1:0];
                OFF_MASK: csr_d.mask     = reg_wdata;
                OFF_MISC: csr_d.lb       = reg_wdata[4];
                OFF_STS:  csr_d.flags    = csr_q.flags & ~reg_wdata[14:12];
                default:  ;
            endcase
        end
        csr_d.flags = csr_d.flags | {q_overflow, mv_done, mv_done};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csr_q <= '{mask: '1, default: '0};
        else        csr_q <= csr_d;
    end

    always_comb begin
        case (reg_addr)
            OFF_STS:  reg_rdata = sts_vec;
            OFF_MASK: reg_rdata = csr_q.mask;
            OFF_STAT: reg_rdata = stat_vec;
            OFF_SRC:  reg_rdata = csr_q.src_addr;
            OFF_DST:  reg_rdata = csr_q.dst_addr;
            OFF_SLEN: reg_rdata = {{(32-LEN_W){1'b0}}, csr_q.src_len};
            OFF_DLEN: reg_rdata = {{(32-LEN_W){1'b0}}, csr_q.dst_len};
            OFF_MISC: reg_rdata = {27'b0, csr_q.lb, 4'b0};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdma_checker.sv
module wdma_checker #(
    parameter int BEAT_W    = 9,
    parameter int MAX_BEATS = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [31:0]       mem_addr,
    input logic              irq,
    input logic [31:0]       sts,
    input logic [31:0]       mask,
    input logic              q_full,
    input logic              q_empty,
    input logic              push,
    input logic              done,
    input logic              lb_active,
    input logic [BEAT_W-1:0] beats_left
);
    p_addr_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_addr[1:0] == 2'b00);

    p_beats_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (beats_left != '0 && beats_left <= BEAT_W'(MAX_BEATS)));

    p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    p_no_write_nolb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> lb_active);

    p_done_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (sts[13] && sts[12]));

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq);

    p_full_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_full && q_empty));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && q_full) |=> sts[14]);
endmodule

bind wdma_cmd_engine wdma_checker #(.BEAT_W(BEAT_W), .MAX_BEATS(CHUNK_BYTES / 4)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .irq       (irq),
    .sts       (sts_vec),
    .mask      (csr_q.mask),
    .q_full    (q_full),
    .q_empty   (q_empty),
    .push      (push_req),
    .done      (mv_done),
    .lb_active (lb_active),
    .beats_left(beats_left)
);

// File: tb/tb_wdma_cmd_engine.sv
module tb_wdma_cmd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_valid, mem_we, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic        ready_en = 1'b1;
    logic        tb_lb = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    // monitor state (written only by the monitor block)
    logic [31:0] dmem [0:1023];
    logic [31:0] rlog [0:2047];
    int rd_n = 0, wr_n = 0, alt_err = 0;
    logic last_rd = 1'b0;

    always #4 clk = ~clk;

    wdma_cmd_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_valid(mem_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .irq(irq)
    );

    function automatic logic [31:0] pat(input logic [9:0] idx);
        return {22'h2A5C3, idx} ^ (32'(idx) * 32'h9E3779B1);
    endfunction

    assign mem_rdata = pat(mem_addr[11:2]);

    always @(negedge clk) mem_ready <= ready_en && ($urandom % 4 != 0);

    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            if (mem_we) begin
                dmem[mem_addr[11:2]] <= mem_wdata;
                wr_n <= wr_n + 1;
                if (!last_rd) alt_err <= alt_err + 1;
                last_rd <= 1'b0;
            end else begin
                rlog[rd_n % 2048] <= mem_addr;
                rd_n <= rd_n + 1;
                if (tb_lb && last_rd) alt_err <= alt_err + 1;
                last_rd <= 1'b1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic prog(input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] sw, input logic [31:0] dw);
        wr(8'h18, s); wr(8'h1C, d); wr(8'h20, sw); wr(8'h24, dw);
    endtask

    task automatic wait_empty(output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            rd(8'h14, v);
            if (v[30]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic lb_copy(input string req, input int sw, input int dw_off, input int len);
        int r0, w0, a0;
        bit ok;
        logic [31:0] v;
        r0 = rd_n; w0 = wr_n; a0 = alt_err;
        prog(32'(sw * 4) | 32'h3, 32'(dw_off * 4) | 32'h2, 32'(len), 32'(len));
        wait_empty(ok);
        check({req, " R3 drained"}, 32'(ok), 32'd1);
        check({req, " R3 read beats"}, 32'(rd_n - r0), 32'(len));
        check({req, " R4 write beats"}, 32'(wr_n - w0), 32'(len));
        check({req, " R4 alternation"}, 32'(alt_err - a0), 32'd0);
        check({req, " R1 first read aligned"}, rlog[r0 % 2048], 32'(sw * 4));
        check({req, " R3 last read addr"}, rlog[(r0 + len - 1) % 2048], 32'((sw + len - 1) * 4));
        begin
            int bad = 0;
            for (int i = 0; i < len; i++)
                if (dmem[dw_off + i] !== pat(10'(sw + i))) bad++;
            check({req, " R4 dest contents"}, 32'(bad), 32'd0);
        end
        rd(8'h0C, v);
        check({req, " R6 done flags"}, v, 32'h0000_3000);
        wr(8'h0C, 32'hFFFF_FFFF);
    endtask

    task automatic run_all();
        logic [31:0] v;
        bit ok;
        int r0, w0;

        do_reset();
        rd(8'h0C, v);  check("R6 reset sts", v, 32'h0);
        rd(8'h10, v);  check("R7 reset mask", v, 32'hFFFF_FFFF);
        rd(8'h14, v);  check("R8 reset status", v, 32'h4000_0000);
        check("R7 reset irq", 32'(irq), 32'd0);

        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, v);  check("R2 length writable bits", v, 32'h07FF_FFFF);
        wr(8'h20, 32'h0);
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h80, v);  check("R11 loopback readback", v, 32'h10);
        wr(8'h18, 32'hDEAD_BEEF);
        rd(8'h18, v);  check("R11 src addr readback", v, 32'hDEAD_BEEF);
        rd(8'h44, v);  check("R11 unmapped reads zero", v, 32'h0);
        tb_lb = 1'b1;

        // long loopback copy spanning two chunks
        lb_copy("long", 0, 512, 300);

        // irq and write-one-to-clear
        prog(32'h0, 32'h800, 32'd1, 32'd1);
        wait_empty(ok);
        check("R7 masked irq low", 32'(irq), 32'd0);
        wr(8'h10, ~32'h0000_2000);
        check("R7 unmasked irq high", 32'(irq), 32'd1);
        wr(8'h0C, 32'h0000_1000);
        rd(8'h0C, v);  check("R6 w1c part done only", v, 32'h0000_2000);
        wr(8'h0C, 32'h0000_2000);
        rd(8'h0C, v);  check("R6 w1c done", v, 32'h0);
        check("R7 irq after clear", 32'(irq), 32'd0);
        wr(8'h10, 32'hFFFF_FFFF);

        // random loopback copies
        for (int k = 0; k < 4; k++)
            lb_copy("rand", int'($urandom % 200), 512 + int'($urandom % 200),
                    1 + int'($urandom % 300));

        // zero length command
        r0 = rd_n; w0 = wr_n;
        prog(32'h40, 32'h900, 32'd0, 32'd0);
        wait_empty(ok);
        check("R10 zero length no reads", 32'(rd_n - r0), 32'd0);
        check("R10 zero length no writes", 32'(wr_n - w0), 32'd0);
        rd(8'h0C, v);  check("R10 zero length done", v, 32'h0000_3000);
        wr(8'h0C, 32'hFFFF_FFFF);

        // non-loopback with zero destination length
        wr(8'h80, 32'h0); tb_lb = 1'b0;
        r0 = rd_n; w0 = wr_n;
        prog(32'h100, 32'h800, 32'd20, 32'd0);
        wait_empty(ok);
        check("R5 nolb drained", 32'(ok), 32'd1);
        check("R5 nolb reads", 32'(rd_n - r0), 32'd20);
        check("R5 nolb no writes", 32'(wr_n - w0), 32'd0);
        rd(8'h0C, v);  check("R5 nolb done", v, 32'h0000_3000);
        wr(8'h0C, 32'hFFFF_FFFF);

        // queue full and overflow
        wr(8'h80, 32'h10); tb_lb = 1'b1;
        ready_en = 1'b0;
        r0 = rd_n;
        for (int i = 0; i < 4; i++) prog(32'(i * 64), 32'h800 + 32'(i * 64), 32'd2, 32'd2);
        rd(8'h14, v);  check("R8 full status", v, 32'h8000_0000);
        rd(8'h0C, v);  check("R9 no overflow yet", v, 32'h0);
        prog(32'h200, 32'h900, 32'd2, 32'd2);
        rd(8'h0C, v);  check("R9 overflow flag", v, 32'h0000_4000);
        wr(8'h10, ~32'h0000_4000);
        check("R7 overflow irq", 32'(irq), 32'd1);
        wr(8'h10, 32'hFFFF_FFFF);
        ready_en = 1'b1;
        wait_empty(ok);
        check("R9 dropped push", 32'(rd_n - r0), 32'd8);
        for (int i = 0; i < 4; i++)
            check("R9 queue order", rlog[(r0 + 2 * i) % 2048], 32'(i * 64));
        wr(8'h0C, 32'hFFFF_FFFF);

        // loopback with destination shorter than source stalls
        r0 = rd_n; w0 = wr_n;
        prog(32'h0, 32'h800, 32'd10, 32'd6);
        repeat (300) @(negedge clk);
        check("R10 stall reads", 32'(rd_n - r0), 32'd6);
        check("R10 stall writes", 32'(wr_n - w0), 32'd6);
        rd(8'h14, v);  check("R10 stall not empty", v, 32'h0);
        rd(8'h0C, v);  check("R10 stall no done", v, 32'h0);

        // non-loopback with nonzero destination length never retires
        do_reset();
        tb_lb = 1'b0;
        r0 = rd_n; w0 = wr_n;
        prog(32'h0, 32'h800, 32'd4, 32'd3);
        repeat (200) @(negedge clk);
        check("R5 nolb reads then hold", 32'(rd_n - r0), 32'd4);
        check("R5 nolb no writes", 32'(wr_n - w0), 32'd0);
        rd(8'h14, v);  check("R5 head not retired", v, 32'h0);
        rd(8'h0C, v);  check("R5 no done", v, 32'h0);
    endtask

    initial begin
        bit wd;
        wd = 1'b0;
        void'($urandom(32'd20240611));
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule